// File: doc/BRIEF.md
# Repeater Downstream Information Handshake Port

This block sits between the downstream-side controller of a content-protection repeater and the upstream receiver core. Software on the downstream side loads the collected receiver ID list and a 16-bit topology word through four 32-bit word registers. A three-flag handshake tells software when loading is allowed. The core raises a request to ask for fresh data. Ready means the buffer may be written. Software sets valid when its data is complete. The core reads the stored bytes and the topology word through a plain indexed read port and pulses a consume input when it is done. That pulse clears valid and raises ready again.

The same register space returns the content stream type that the core last received. Its valid flag stays set until software reads that word. A word-0x03 flag tells the core whether a capable downstream device is present, so that it acts as a repeater or as an endpoint. The ID list is held as bytes in write order, up to a parameterised number of five-byte IDs.

Top module: `rpt_info_port`

## Requirements
- R1: After reset, every readable register reads 0, `core_list_valid` is 0, `core_list_len` is 0 and `repeater_mode` is 0.
- R2: A pulse on `core_req` sets the request flag (word 0x01 bit 18) and the ready flag (bit 17) in the next cycle and clears valid (bit 16). Request is never 1 while ready is 0.
- R3: While ready is 1, a write to word 0x00 appends `wdata[7:0]` to the list. The core reads byte k (k counted from 0 in write order) at `core_rd_idx`=k, and `core_list_len` gives the number of bytes stored. Writes to word 0x00 while ready is 0 are ignored.
- R4: The list holds at most `MAX_IDS`*`ID_BYTES` bytes. A write to word 0x00 when the list is full leaves the length and the content unchanged.
- R5: While ready is 1, a write to word 0x01 stores `wdata[15:0]` as the topology word. Its layout is: bits 15:12 reserved, 11:9 depth, 8:4 device count, 3 too many devices, 2 too many levels, 1 newer-version repeater below, 0 legacy device below. It reads back in bits 15:0 and drives `core_rxinfo`.
- R6: A word-0x01 write with `wdata[16]`=1 while ready is 1 sets valid and clears request and ready in the next cycle. `core_list_valid` follows valid, and valid and ready are never 1 together.
- R7: A pulse on `core_consume` while valid is 1 clears valid and sets ready in the next cycle.
- R8: When `core_req` arrives while request is 0, the list length returns to 0.
- R9: A pulse on `core_type_wr` stores the type and sets the type valid flag (word 0x02 bit 8). Code 0x00 reads as 0x00 in bits 7:0, and every code from 0x01 to 0xFF reads as 0x01.
- R10: A read of word 0x02 clears the type valid flag in the next cycle, unless `core_type_wr` is pulsed in the same cycle.
- R11: Word 0x03 bit 0 is read/write and drives `repeater_mode`. All its other bits read 0.
- R12: Reads of word 0x00 return 0. Write bits 31:19 and 18:17 of word 0x01 have no effect. `rdata` is 0 when `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr while rd_en |
| core_req | input | 1 | Core asks for a fresh list (pulse) |
| core_consume | input | 1 | Core has read the list (pulse) |
| core_type_wr | input | 1 | Core delivers a stream type (pulse) |
| core_type | input | 8 | Stream type code from the core |
| core_rd_idx | input | PTR_W | Byte index into the stored list |
| core_rd_byte | output | 8 | List byte at core_rd_idx |
| core_list_len | output | PTR_W | Number of list bytes stored |
| core_rxinfo | output | 16 | Stored topology word |
| core_list_valid | output | 1 | List and topology word are complete |
| repeater_mode | output | 1 | Repeater-mode flag |

## Verification
The bench builds the block with `MAX_IDS`=3 and `ID_BYTES`=5, which gives a 15-byte list. It writes 17 bytes in one pass, so the full-buffer drop is reached after a few writes rather than after 155. The stored bytes are then read back at the ends and in the middle of the list. With these values the full handshake can be driven twice: request, fill, valid, consume, and then a second request that clears the pointer. A table of stream type codes covers both defined codes and the reserved range, including 0x02 and 0xFF.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [1:0] {
    A_LIST = 2'd0,
    A_INFO = 2'd1,
    A_TYPE = 2'd2,
    A_MODE = 2'd3
  } rpt_addr_e;

  localparam int unsigned VALID_BIT = 16;
  localparam int unsigned READY_BIT = 17;
  localparam int unsigned REQ_BIT   = 18;
  localparam int unsigned INFO_W    = 16;
  localparam int unsigned TVLD_BIT  = 8;
endpackage

// File: rtl/rpt_list_buf.sv
module rpt_list_buf #(
  parameter int unsigned DEPTH = 155,
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [7:0]       dout,
  output logic [PTR_W-1:0] len
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] len_q, len_d;
  logic             full, do_push;

  assign full    = (len_q == PTR_W'(DEPTH));
  assign do_push = push & ~full & ~clr;

  always_comb begin
    len_d = len_q;
    if (clr)          len_d = '0;
    else if (do_push) len_d = len_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[len_q] <= din;
  end

  assign dout = (rd_idx < PTR_W'(DEPTH)) ? mem[rd_idx] : 8'h00;
  assign len  = len_q;

  // R4
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= PTR_W'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !clr) |=> $stable(len_q));
endmodule

// File: rtl/rpt_hs_ctrl.sv
module rpt_hs_ctrl
  import rpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_consume,
  input  logic              info_wr,
  input  logic [INFO_W:0]   info_wdata,
  output logic              request,
  output logic              ready,
  output logic              valid,
  output logic [INFO_W-1:0] rxinfo,
  output logic              req_rise
);
  logic              req_q, req_d, rdy_q, rdy_d, vld_q, vld_d;
  logic [INFO_W-1:0] info_q, info_d;

  always_comb begin
    req_d  = req_q;
    rdy_d  = rdy_q;
    vld_d  = vld_q;
    info_d = info_q;
    if (core_req) begin
      req_d = 1'b1;
      rdy_d = 1'b1;
      vld_d = 1'b0;
    end else if (core_consume && vld_q) begin
      vld_d = 1'b0;
      rdy_d = 1'b1;
    end else if (info_wr && rdy_q) begin
      info_d = info_wdata[INFO_W-1:0];
      if (info_wdata[INFO_W]) begin
        vld_d = 1'b1;
        req_d = 1'b0;
        rdy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      rdy_q  <= 1'b0;
      vld_q  <= 1'b0;
      info_q <= '0;
    end else begin
      req_q  <= req_d;
      rdy_q  <= rdy_d;
      vld_q  <= vld_d;
      info_q <= info_d;
    end
  end

  assign request  = req_q;
  assign ready    = rdy_q;
  assign valid    = vld_q;
  assign rxinfo   = info_q;
  assign req_rise = core_req & ~req_q;

  // R2
  req_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> rdy_q);

  // R6
  valid_excl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !rdy_q);

  // R7
  consume_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_consume && vld_q && !core_req) |=> (rdy_q && !vld_q));
endmodule

// File: rtl/rpt_type_reg.sv
module rpt_type_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set,
  input  logic [7:0] code,
  input  logic       sw_rd,
  output logic [7:0] type_o,
  output logic       valid_o
);
  logic [7:0] type_q, type_d;
  logic       vld_q, vld_d;

  always_comb begin
    type_d = type_q;
    vld_d  = vld_q;
    if (set) begin
      type_d = (code == 8'h00) ? 8'h00 : 8'h01;
      vld_d  = 1'b1;
    end else if (sw_rd) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      type_q <= type_d;
      vld_q  <= vld_d;
    end
  end

  assign type_o  = type_q;
  assign valid_o = vld_q;

  // R9
  type_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    type_q <= 8'h01);

  // R10
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && !set) |=> !vld_q);
endmodule

// File: rtl/rpt_info_port.sv
module rpt_info_port
  import rpt_pkg::*;
#(
  parameter int unsigned ID_BYTES = 5,
  parameter int unsigned MAX_IDS  = 31,
  localparam int unsigned DEPTH   = ID_BYTES * MAX_IDS,
  localparam int unsigned PTR_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              core_req,
  input  logic              core_consume,
  input  logic              core_type_wr,
  input  logic [7:0]        core_type,
  input  logic [PTR_W-1:0]  core_rd_idx,
  output logic [7:0]        core_rd_byte,
  output logic [PTR_W-1:0]  core_list_len,
  output logic [15:0]       core_rxinfo,
  output logic              core_list_valid,
  output logic              repeater_mode
);
  logic              request, ready, valid, req_rise;
  logic [INFO_W-1:0] rxinfo;
  logic [7:0]        type_val;
  logic              type_vld;
  logic              mode_q, mode_d;
  logic              list_push, info_wr, mode_wr, type_rd;
  logic              unused_bits;

  assign list_push   = wr_en & (addr == A_LIST) & ready;
  assign info_wr     = wr_en & (addr == A_INFO);
  assign mode_wr     = wr_en & (addr == A_MODE);
  assign type_rd     = rd_en & (addr == A_TYPE);
  assign unused_bits = ^wdata[31:INFO_W+1];

  rpt_list_buf #(.DEPTH(DEPTH), .PTR_W(PTR_W)) i_list (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (req_rise),
    .push   (list_push),
    .din    (wdata[7:0]),
    .rd_idx (core_rd_idx),
    .dout   (core_rd_byte),
    .len    (core_list_len)
  );

  rpt_hs_ctrl i_hs (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_req     (core_req),
    .core_consume (core_consume),
    .info_wr      (info_wr),
    .info_wdata   (wdata[INFO_W:0]),
    .request      (request),
    .ready        (ready),
    .valid        (valid),
    .rxinfo       (rxinfo),
    .req_rise     (req_rise)
  );

  rpt_type_reg i_type (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (core_type_wr),
    .code    (core_type),
    .sw_rd   (type_rd),
    .type_o  (type_val),
    .valid_o (type_vld)
  );

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) mode_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_INFO: begin
          rdata[INFO_W-1:0] = rxinfo;
          rdata[VALID_BIT]  = valid;
          rdata[READY_BIT]  = ready;
          rdata[REQ_BIT]    = request;
        end
        A_TYPE: begin
          rdata[7:0]      = type_val;
          rdata[TVLD_BIT] = type_vld;
        end
        A_MODE:  rdata[0] = mode_q;
        default: rdata = '0;
      endcase
    end
  end

  assign core_rxinfo     = rxinfo;
  assign core_list_valid = valid;
  assign repeater_mode   = mode_q;

  // R3
  locked_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LIST && !ready && !core_req) |=> $stable(core_list_len));

  // R8
  req_clears_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !request) |=> (core_list_len == '0));

  // R11
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (repeater_mode == $past(wdata[0])));
endmodule

// File: tb/test_rpt_info_port.sv
module test_rpt_info_port;
  localparam int unsigned IDB   = 5;
  localparam int unsigned NIDS  = 3;
  localparam int unsigned LIM   = IDB * NIDS;
  localparam int unsigned PW    = $clog2(LIM + 1);

  // type table: {code, expected bits 7:0}
  localparam logic [15:0] TVEC [6] = '{
    16'h00_00, 16'h01_01, 16'h02_01, 16'h7F_01, 16'hFF_01, 16'h00_00
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          core_req = 1'b0, core_consume = 1'b0, core_type_wr = 1'b0;
  logic [7:0]    core_type = '0;
  logic [PW-1:0] core_rd_idx = '0;
  logic [7:0]    core_rd_byte;
  logic [PW-1:0] core_list_len;
  logic [15:0]   core_rxinfo;
  logic          core_list_valid, repeater_mode;

  int total = 0;
  int bad   = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  rpt_info_port #(.ID_BYTES(IDB), .MAX_IDS(NIDS)) i_rpt_info_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .core_req(core_req),
    .core_consume(core_consume), .core_type_wr(core_type_wr),
    .core_type(core_type), .core_rd_idx(core_rd_idx),
    .core_rd_byte(core_rd_byte), .core_list_len(core_list_len),
    .core_rxinfo(core_rxinfo), .core_list_valid(core_list_valid),
    .repeater_mode(repeater_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); core_req = 1'b1;
    @(negedge clk); core_req = 1'b0;
  endtask

  task automatic pulse_consume();
    @(negedge clk); core_consume = 1'b1;
    @(negedge clk); core_consume = 1'b0;
  endtask

  task automatic push_type(input logic [7:0] c);
    @(negedge clk); core_type_wr = 1'b1; core_type = c;
    @(negedge clk); core_type_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, rv); check("R1 info", rv, 32'h0);
    rd(2'd2, rv); check("R1 type", rv, 32'h0);
    rd(2'd3, rv); check("R1 mode", rv, 32'h0);
    check("R1 list_valid", {31'b0, core_list_valid}, 32'h0);
    check("R1 len", 32'(core_list_len), 32'h0);
    check("R1 repeater_mode", {31'b0, repeater_mode}, 32'h0);
    // R12 rdata idle
    check("R12 idle rdata", rdata, 32'h0);

    // R3 list write while not ready is ignored
    wr(2'd0, 32'h0000_0055);
    check("R3 locked write", 32'(core_list_len), 32'h0);

    // R2 request
    pulse_req();
    rd(2'd1, rv); check("R2 req+ready", rv, 32'h0006_0000);

    // R3/R4 fill beyond limit
    for (int i = 0; i < LIM + 2; i++) wr(2'd0, 32'hDEAD_BE00 | 32'(8'hA0 + i));
    check("R4 len capped", 32'(core_list_len), 32'(LIM));
    core_rd_idx = '0;              #1 check("R3 byte first", 32'(core_rd_byte), 32'hA0);
    core_rd_idx = PW'(7);          #1 check("R3 byte mid", 32'(core_rd_byte), 32'hA7);
    core_rd_idx = PW'(LIM - 1);    #1 check("R4 last kept", 32'(core_rd_byte), 32'(8'hA0 + LIM - 1));

    // R5/R12 topology write, junk high bits ignored
    wr(2'd1, 32'hFFF8_0A35);
    rd(2'd1, rv); check("R5 R12 topology", rv, 32'h0006_0A35);
    check("R5 core_rxinfo", 32'(core_rxinfo), 32'h0A35);

    // R6 valid
    wr(2'd1, 32'h0001_0B21);
    rd(2'd1, rv); check("R6 valid", rv, 32'h0001_0B21);
    check("R6 core_list_valid", {31'b0, core_list_valid}, 32'h1);

    // R3 writes locked after valid
    pulse_req(); // would change state; avoid: re-establish below
    // request set again -> pointer not cleared since request was 0 -> it is cleared (R8)
    check("R8 len cleared", 32'(core_list_len), 32'h0);
    rd(2'd1, rv); check("R2 re-request", rv, 32'h0006_0B21);
    wr(2'd0, 32'h0000_0011);
    wr(2'd1, 32'h0001_0C44);
    wr(2'd0, 32'h0000_0022);
    check("R3 locked after valid", 32'(core_list_len), 32'h1);

    // R7 consume
    pulse_consume();
    rd(2'd1, rv); check("R7 consume", rv, 32'h0002_0C44);
    check("R7 core_list_valid", {31'b0, core_list_valid}, 32'h0);

    // R9/R10 type table
    for (int k = 0; k < 6; k++) begin
      push_type(TVEC[k][15:8]);
      rd(2'd2, rv); check("R9 type", rv, 32'h100 | 32'(TVEC[k][7:0]));
      rd(2'd2, rv); check("R10 cleared", rv, 32'(TVEC[k][7:0]));
    end

    // R10 read and core write in same cycle keep valid
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd2; core_type_wr = 1'b1; core_type = 8'h09;
    @(negedge clk);
    rd_en = 1'b0; core_type_wr = 1'b0;
    rd(2'd2, rv); check("R10 same-cycle set", rv, 32'h0000_0101);

    // R11 mode
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, rv); check("R11 mode set", rv, 32'h1);
    check("R11 repeater_mode", {31'b0, repeater_mode}, 32'h1);
    wr(2'd3, 32'hFFFF_FFFE);
    rd(2'd3, rv); check("R11 mode clear", rv, 32'h0);

    // R12 word 0 reads zero
    rd(2'd0, rv); check("R12 list read", rv, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule